// File: doc/BRIEF.md
# Codec power-down and initialization sequencer

This block runs the digital side of an audio converter's power states. An asynchronous active-low power-down pin is brought into the system clock domain through a two-flop synchronizer. While the pin is low, the ADC and DAC paths are held down, the filters are held in reset, all DAC channels are muted and the zero-detect flags are forced low. A one-cycle register-reset pulse marks each entry into pin power-down.

After the pin rises, the block counts frame strobes (one per sample frame) to time three windows: the ADC data gate, the DAC initialization window and a short zero-detect hold. It also raises a one-cycle mute request on the pin's falling edge and again at a fixed frame count after the rising edge, so that downstream logic can cover the two disturbance points.

The ADC path and the DAC path can also be powered down through software power bits without a register reset. Turning a path's bit back on restarts that path's initialization window. Each of the four DAC channels has its own power bit. When every DAC power bit is off, the zero-detect flags are driven high.

Top module: `codec_pwr_seq`

## Requirements
- R1: While the system reset rst_ni is low, filt_rst_o is 1, adc_valid_o is 0, dac_mute_o is 4'b1111, dac_init_o is 4'b0000 and zd_o is 2'b00.
- R2: While the synchronized pin is low, filt_rst_o is 1, adc_valid_o is 0, every dac_mute_o bit is 1 and zd_o is 2'b00, whatever the power bits and zd_raw_i are.
- R3: A falling edge of pdn_ni gives a one-cycle pulse on reg_rst_o and on mute_req_o in the second clock after the edge is sampled. The power bits never produce a reg_rst_o pulse.
- R4: After the pin rises with adc_pwr_i at 1, adc_valid_o stays 0 through the first ADC_INIT-1 frame strobes and goes to 1 right after strobe ADC_INIT (522).
- R5: After the pin rises with dac_pwr_i at 1, dac_init_o[k] equals ch_pwr_i[k] and all channels are muted through strobe DAC_INIT-1. After strobe DAC_INIT (516), dac_init_o is 0.
- R6: After the pin rises, zd_o stays 2'b00 through the first ZD_HOLD-1 strobes. After strobe ZD_HOLD (10), it follows zd_raw_i.
- R7: mute_req_o pulses for exactly one cycle right after frame strobe CLICK_AT (512) following the pin's rise.
- R8: With adc_pwr_i at 0, adc_valid_o is 0. A 0-to-1 change of adc_pwr_i (or of dac_pwr_i) restarts that path's full window counted in strobes.
- R9: With dac_pwr_i at 0, all channels are muted. Once the hold of R6 has ended, zd_o is 2'b11 when ch_pwr_i is 0, and zd_raw_i otherwise. The ADC path keeps adc_valid_o at 1.
- R10: With dac_pwr_i at 1 and the DAC window done, dac_mute_o equals ~ch_pwr_i, so each channel bit affects only its own channel.
- R11: If the pin falls during a count, all windows abort. The next rise restarts every count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| pdn_ni | input | 1 | Asynchronous active-low power-down pin |
| frame_i | input | 1 | One-cycle strobe per sample frame |
| adc_pwr_i | input | 1 | ADC path power bit |
| dac_pwr_i | input | 1 | DAC path power bit |
| ch_pwr_i | input | 4 | Per-channel DAC power bits |
| zd_raw_i | input | 2 | Zero-detect result from the data path |
| reg_rst_o | output | 1 | One-cycle control register reset pulse |
| filt_rst_o | output | 1 | Filter reset, high during pin power-down |
| adc_valid_o | output | 1 | ADC data pass gate; 0 forces serial data to zero |
| dac_mute_o | output | 4 | Per-channel DAC mute |
| dac_init_o | output | 4 | Per-channel DAC initialization in progress |
| zd_o | output | 2 | Zero-detect flags |
| mute_req_o | output | 1 | One-cycle external mute request |

## Verification
The assertions assume that frame_i is a single-cycle strobe and that the power bits are synchronous to clk_i. They also assume that the pin is the only source of register resets. The stimulus drives every input at the falling clock edge, holds frame strobes off for several cycles around a pin edge so that the synchronizer delay never shifts the count, and spaces strobes four cycles apart. Random phases vary the channel bits and zd_raw_i freely. In those phases dac_pwr_i is held at a fixed level, so that no window restarts unless a directed case intends it.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic [1:0] {
    ZD_FORCE_LO = 2'd0,
    ZD_FORCE_HI = 2'd1,
    ZD_PASS     = 2'd2
  } zd_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b1; // entry from reset counts as a fall
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign fall_o  = prev_q & ~s2_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic frame_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LEN + 1);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;
  logic         run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i || !run_q) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (frame_i && !done_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q & run_i;
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int unsigned N_CH     = 4,
  parameter int unsigned N_ZD     = 2,
  parameter int unsigned ADC_INIT = 522,
  parameter int unsigned DAC_INIT = 516,
  parameter int unsigned ZD_HOLD  = 10,
  parameter int unsigned CLICK_AT = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pdn_ni,
  input  logic            frame_i,
  input  logic            adc_pwr_i,
  input  logic            dac_pwr_i,
  input  logic [N_CH-1:0] ch_pwr_i,
  input  logic [N_ZD-1:0] zd_raw_i,
  output logic            reg_rst_o,
  output logic            filt_rst_o,
  output logic            adc_valid_o,
  output logic [N_CH-1:0] dac_mute_o,
  output logic [N_CH-1:0] dac_init_o,
  output logic [N_ZD-1:0] zd_o,
  output logic            mute_req_o
);
  logic pdn_s, pdn_fall;
  logic adc_run, dac_run;
  logic adc_done, dac_done, zd_done, click_done, click_done_q;
  logic dac_all_off;
  zd_sel_e zd_sel;

  pin_sync i_pin_sync (
    .clk_i, .rst_ni, .pin_i(pdn_ni), .level_o(pdn_s), .fall_o(pdn_fall)
  );

  assign adc_run = pdn_s & adc_pwr_i;
  assign dac_run = pdn_s & dac_pwr_i;

  frame_timer #(.LEN(ADC_INIT)) i_adc_tmr (
    .clk_i, .rst_ni, .run_i(adc_run), .frame_i, .done_o(adc_done)
  );
  frame_timer #(.LEN(DAC_INIT)) i_dac_tmr (
    .clk_i, .rst_ni, .run_i(dac_run), .frame_i, .done_o(dac_done)
  );
  frame_timer #(.LEN(ZD_HOLD)) i_zd_tmr (
    .clk_i, .rst_ni, .run_i(pdn_s), .frame_i, .done_o(zd_done)
  );
  frame_timer #(.LEN(CLICK_AT)) i_click_tmr (
    .clk_i, .rst_ni, .run_i(pdn_s), .frame_i, .done_o(click_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) click_done_q <= 1'b0;
    else         click_done_q <= click_done;
  end

  assign reg_rst_o   = pdn_fall;
  assign filt_rst_o  = ~pdn_s;
  assign adc_valid_o = adc_done;
  assign mute_req_o  = pdn_fall | (click_done & ~click_done_q);
  assign dac_all_off = ~dac_pwr_i & ~(|ch_pwr_i);

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign dac_mute_o[k] = ~(dac_done & ch_pwr_i[k]);
    assign dac_init_o[k] = dac_run & ~dac_done & ch_pwr_i[k];
  end

  always_comb begin
    if (!pdn_s || !zd_done) zd_sel = ZD_FORCE_LO;
    else if (dac_all_off)   zd_sel = ZD_FORCE_HI;
    else                    zd_sel = ZD_PASS;
  end

  always_comb begin
    unique case (zd_sel)
      ZD_FORCE_HI: zd_o = '1;
      ZD_PASS:     zd_o = zd_raw_i;
      default:     zd_o = '0;
    endcase
  end
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned N_ZD = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_i,
  input logic            adc_pwr_i,
  input logic            dac_pwr_i,
  input logic [N_CH-1:0] ch_pwr_i,
  input logic            reg_rst_o,
  input logic            filt_rst_o,
  input logic            adc_valid_o,
  input logic [N_CH-1:0] dac_mute_o,
  input logic [N_CH-1:0] dac_init_o,
  input logic [N_ZD-1:0] zd_o,
  input logic            zd_done
);
  AST_ZD_LOW_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_o |-> (zd_o == '0)); // R2
  AST_MUTE_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_o |-> (&dac_mute_o)); // R2
  AST_ADC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_rst_o || !adc_pwr_i) |-> !adc_valid_o); // R8
  AST_INIT_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dac_init_o & ~dac_mute_o) == '0)); // R5
  AST_REGRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !reg_rst_o); // R3
  AST_REGRST_PIN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rst_o) |-> filt_rst_o); // R3
  AST_VALID_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_valid_o) |-> $past(frame_i)); // R4
  AST_ZD_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filt_rst_o && zd_done && !dac_pwr_i && ch_pwr_i == '0) |-> (&zd_o)); // R9
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(.N_CH(N_CH), .N_ZD(N_ZD)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .adc_pwr_i(adc_pwr_i),
  .dac_pwr_i(dac_pwr_i), .ch_pwr_i(ch_pwr_i), .reg_rst_o(reg_rst_o),
  .filt_rst_o(filt_rst_o), .adc_valid_o(adc_valid_o), .dac_mute_o(dac_mute_o),
  .dac_init_o(dac_init_o), .zd_o(zd_o), .zd_done(zd_done)
);

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pdn_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       adc_pwr_i = 1'b0;
  logic       dac_pwr_i = 1'b0;
  logic [3:0] ch_pwr_i = 4'b0;
  logic [1:0] zd_raw_i = 2'b0;
  logic       reg_rst_o, filt_rst_o, adc_valid_o, mute_req_o;
  logic [3:0] dac_mute_o, dac_init_o;
  logic [1:0] zd_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk_i = ~clk_i;

  codec_pwr_seq i_codec_pwr_seq (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_zd(input logic dpwr, input logic [3:0] ch,
                                        input logic [1:0] raw);
    if (!dpwr && ch == 4'b0) return 2'b11;
    return raw;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // strobe sits across one posedge; returns at the negedge right after it
  task automatic strobe();
    frame_i = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
  endtask

  task automatic strobes(input int n);
    repeat (n) begin strobe(); idle(3); end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 filt_rst", {7'd0, filt_rst_o}, 8'd1);
    chk("R1 adc_valid", {7'd0, adc_valid_o}, 8'd0);
    chk("R1 mute", {4'd0, dac_mute_o}, 8'hf);
    chk("R1 init", {4'd0, dac_init_o}, 8'h0);
    chk("R1 zd", {6'd0, zd_o}, 8'h0);
    rst_ni = 1'b1;
    adc_pwr_i = 1'b1; dac_pwr_i = 1'b1; ch_pwr_i = 4'b1011; zd_raw_i = 2'b11;
    idle(4);
    chk("R2 zd low pin pd", {6'd0, zd_o}, 8'h0);
    chk("R2 mute pin pd", {4'd0, dac_mute_o}, 8'hf);
    chk("R2 filt_rst", {7'd0, filt_rst_o}, 8'd1);
    zd_raw_i = 2'b01;
    // power-up sequence
    pdn_ni = 1'b1;
    idle(6);
    chk("R2 filt_rst release", {7'd0, filt_rst_o}, 8'd0);
    for (int k = 1; k <= 522; k++) begin
      strobe();
      if (k == 512) begin
        chk("R7 mute_req at 512", {7'd0, mute_req_o}, 8'd1);
        @(negedge clk_i);
        chk("R7 mute_req one cycle", {7'd0, mute_req_o}, 8'd0);
        idle(2);
      end else begin
        if (k == 9)   chk("R6 zd held", {6'd0, zd_o}, 8'h0);
        if (k == 10)  chk("R6 zd follows", {6'd0, zd_o}, 8'h1);
        if (k == 100) chk("R7 no early mute_req", {7'd0, mute_req_o}, 8'd0);
        if (k == 515) begin
          chk("R5 init active", {4'd0, dac_init_o}, 8'hb);
          chk("R5 mute in init", {4'd0, dac_mute_o}, 8'hf);
        end
        if (k == 516) begin
          chk("R5 init over", {4'd0, dac_init_o}, 8'h0);
          chk("R10 mute after init", {4'd0, dac_mute_o}, 8'h4);
        end
        if (k == 521) chk("R4 adc gated", {7'd0, adc_valid_o}, 8'd0);
        if (k == 522) chk("R4 adc valid", {7'd0, adc_valid_o}, 8'd1);
        idle(3);
      end
    end
    // random per-channel mutes and zero-detect pass
    for (int i = 0; i < 150; i++) begin
      ch_pwr_i = 4'($urandom);
      zd_raw_i = 2'($urandom);
      @(negedge clk_i);
      chk("R10 mute per ch", {4'd0, dac_mute_o}, {4'd0, ~ch_pwr_i});
      chk("R10 zd pass", {6'd0, zd_o}, {6'd0, exp_zd(1'b1, ch_pwr_i, zd_raw_i)});
    end
    // DAC register power-down
    dac_pwr_i = 1'b0;
    for (int i = 0; i < 150; i++) begin
      ch_pwr_i = (i % 4 == 0) ? 4'b0 : 4'($urandom);
      zd_raw_i = 2'($urandom);
      @(negedge clk_i);
      chk("R9 zd", {6'd0, zd_o}, {6'd0, exp_zd(1'b0, ch_pwr_i, zd_raw_i)});
      chk("R9 mute all", {4'd0, dac_mute_o}, 8'hf);
      chk("R9 no reg_rst", {7'd0, reg_rst_o}, 8'd0);
      chk("R9 adc kept", {7'd0, adc_valid_o}, 8'd1);
    end
    // ADC register power-down and restart, DAC restart with it
    adc_pwr_i = 1'b0; ch_pwr_i = 4'b0110;
    idle(2);
    chk("R8 adc off", {7'd0, adc_valid_o}, 8'd0);
    chk("R8 no reg_rst", {7'd0, reg_rst_o}, 8'd0);
    adc_pwr_i = 1'b1; dac_pwr_i = 1'b1;
    idle(6);
    strobes(515);
    chk("R8 dac init restarted", {4'd0, dac_init_o}, 8'h6);
    strobe(); idle(3);
    chk("R8 dac init over", {4'd0, dac_init_o}, 8'h0);
    strobes(5);
    chk("R8 adc window restarted", {7'd0, adc_valid_o}, 8'd1 ^ 8'd1);
    strobe();
    chk("R8 adc valid again", {7'd0, adc_valid_o}, 8'd1);
    idle(3);
    // pin fall while running
    pdn_ni = 1'b0;
    idle(2);
    chk("R3 reg_rst pulse", {7'd0, reg_rst_o}, 8'd1);
    chk("R3 mute_req pulse", {7'd0, mute_req_o}, 8'd1);
    idle(1);
    chk("R3 reg_rst ends", {7'd0, reg_rst_o}, 8'd0);
    chk("R3 mute_req ends", {7'd0, mute_req_o}, 8'd0);
    chk("R2 adc off pin", {7'd0, adc_valid_o}, 8'd0);
    chk("R2 zd pin", {6'd0, zd_o}, 8'h0);
    // abort mid-count and restart
    pdn_ni = 1'b1;
    idle(6);
    strobes(300);
    pdn_ni = 1'b0;
    idle(6);
    pdn_ni = 1'b1;
    idle(6);
    strobes(521);
    chk("R11 adc count restarted", {7'd0, adc_valid_o}, 8'd0);
    chk("R11 dac done", {4'd0, dac_init_o}, 8'h0);
    strobe();
    chk("R11 adc valid", {7'd0, adc_valid_o}, 8'd1);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule